// File: doc/BRIEF.md
# Bidirectional Ring Transfer Arbiter

This block decides which participant on a twelve-stop ring may start a block transfer and on which channel it travels. The ring carries four one-way channels, two turning clockwise and two counter-clockwise, each one beat of 16 bytes wide. A participant holds a request that names a destination. The arbiter routes it the short way round, looks for a channel in that direction whose segments along the route are idle, and accepts at most one request per clock.

An accepted transfer always moves eight beats. The beats advance one segment per cycle. The block models this movement with per-segment hold counters and with strobes that mark the cycles in which the sender reads out a beat and the receiver takes one in. Requests that can never be served, such as one aimed at the requester itself or at a stop that does not exist, are answered with an error strobe at once.

A requester drives `req_valid` with its destination and keeps them until it sees either its `gnt` bit or its `err` bit in the same cycle. The transfer counts as accepted at the rising edge that ends that cycle.

Top module: `ring_arbiter`

## Requirements
- R1: With d = (dst - src) mod 12, a transfer runs clockwise over d hops when d <= 6 and counter-clockwise over 12 - d hops otherwise. A tie at six hops goes clockwise. `gnt_cw` and `gnt_hops` report the choice.
- R2: Channels 0 and 1 run clockwise and channels 2 and 3 run counter-clockwise. A grant names the lowest-numbered channel of the chosen direction that is usable.
- R3: A request whose destination equals its source, or is 12 or more, raises that participant's `err` bit in the same cycle and never raises its `gnt` bit.
- R4: `gnt` is combinational from the requests and the ring state, and at most one of its bits is set in any cycle.
- R5: Among eligible requesters, the winner is the first one found when searching upward from the participant after the previous winner, wrapping round. The search starts from participant 0 after reset.
- R6: After a channel grant, that channel accepts no new grant in the next two cycles.
- R7: A segment at position k along a granted route (k = 0 at the source) stays occupied on that channel for 8 + k cycles after the grant edge. A request whose route touches an occupied segment cannot use that channel.
- R8: A source's `src_beat` bit is high in cycles 1 through 8 after its grant edge. That source receives no new grant before cycle 9.
- R9: A destination's `dst_beat` bit is high in cycles h+1 through h+8 after the grant edge, where h is the hop count. That destination accepts no new transfer before cycle h+9.
- R10: After reset no beat strobes are active, no channel is occupied, and with no requests neither `gnt` nor `err` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 12 | One request bit per participant |
| req_dst | input | 48 | Destination of participant i in bits [4i+3:4i] |
| gnt | output | 12 | One-hot grant, same cycle as the request |
| err | output | 12 | Refusal of unroutable requests |
| gnt_chan | output | 2 | Channel of the current grant |
| gnt_cw | output | 1 | Current grant travels clockwise |
| gnt_hops | output | 3 | Hop count of the current grant |
| src_beat | output | 12 | Participant is reading out a beat |
| dst_beat | output | 12 | Participant is taking in a beat |

## Verification
Every source and destination pair is offered alone on an idle ring. This pins down the direction, the hop count, the tie at six hops, refusal of self-addressed requests and the beat windows at both ends. Three simultaneous clockwise requests on disjoint segments separate the channel-spacing rule from segment conflicts, and they show two transfers sharing one channel. Overlapping routes, a busy sender and a busy receiver are each set up so that the release cycle predicted by the hold rules is distinct from any neighbouring cycle. A follow-on contention pattern shows the round-robin pointer moving past the last winner.

// File: rtl/ring_pkg.sv
package ring_pkg;
   // Non-negative modulo for positions on the ring.
   function automatic int ring_wrap(input int v, input int n);
      return ((v % n) + n) % n;
   endfunction
endpackage

// File: rtl/ring_route.sv
module ring_route
   import ring_pkg::*;
#(
   parameter int N    = 12,
   parameter int MAXH = 6,
   parameter int SRC  = 0
)(
   input  logic [$clog2(N)-1:0]    dst,
   output logic                    bad,
   output logic                    cw,
   output logic [$clog2(MAXH+1)-1:0] hops,
   output logic [N-1:0]            path
);
   localparam int HW = $clog2(MAXH + 1);

   always_comb begin
      int dcw;
      dcw  = ring_wrap(int'(dst) - SRC, N);
      bad  = (int'(dst) >= N) || (int'(dst) == SRC);
      cw   = (dcw <= MAXH);
      hops = cw ? HW'(dcw) : HW'(N - dcw);
      path = '0;
      for (int k = 0; k < MAXH; k++) begin
         if (k < int'(hops))
            path[ring_wrap(cw ? SRC + k : SRC - k, N)] = 1'b1;
      end
   end
endmodule

// File: rtl/ring_chan.sv
module ring_chan
   import ring_pkg::*;
#(
   parameter int N     = 12,
   parameter int BEATS = 8,
   parameter int MAXH  = 6,
   parameter int GAP   = 3,
   parameter bit IS_CW = 1'b1
)(
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 load,
   input  logic [N-1:0]         path,
   input  logic [$clog2(N)-1:0] src,
   output logic [N-1:0]         seg_busy,
   output logic                 start_ok
);
   localparam int SW = $clog2(BEATS + MAXH);
   localparam int GW = $clog2(GAP + 1);

   logic [GW-1:0] gap_q;

   for (genvar j = 0; j < N; j++) begin : g_seg
      logic [SW-1:0] hold_q;
      logic [SW-1:0] hold_ld;
      assign hold_ld = SW'(BEATS + (IS_CW ? ring_wrap(j - int'(src), N)
                                          : ring_wrap(int'(src) - j, N)));
      always_ff @(posedge clk) begin
         if (rst)                  hold_q <= '0;
         else if (load && path[j]) hold_q <= hold_ld;
         else if (hold_q != '0)    hold_q <= hold_q - 1'b1;
      end
      assign seg_busy[j] = (hold_q != '0);
   end

   always_ff @(posedge clk) begin
      if (rst)                gap_q <= '0;
      else if (load)          gap_q <= GW'(GAP - 1);
      else if (gap_q != '0)   gap_q <= gap_q - 1'b1;
   end
   assign start_ok = (gap_q == '0);

   p_seg_clear_r7: assert property (@(posedge clk) disable iff (rst)
      load |-> ((path & seg_busy) == '0));
   p_start_ok_r6: assert property (@(posedge clk) disable iff (rst)
      load |-> start_ok);
   if (GAP > 1) begin : g_gap_chk
      p_gap_block_r6: assert property (@(posedge clk) disable iff (rst)
         load |=> !start_ok);
   end
endmodule

// File: rtl/ring_port.sv
module ring_port #(
   parameter int N     = 12,
   parameter int BEATS = 8,
   parameter int MAXH  = 6
)(
   input  logic                      clk,
   input  logic                      rst,
   input  logic [N-1:0]              src_load,
   input  logic [N-1:0]              dst_load,
   input  logic [$clog2(MAXH+1)-1:0] hops,
   output logic [N-1:0]              src_free,
   output logic [N-1:0]              dst_free,
   output logic [N-1:0]              src_beat,
   output logic [N-1:0]              dst_beat
);
   localparam int RW = $clog2(BEATS + 1);
   localparam int WW = $clog2(BEATS + MAXH + 1);

   for (genvar i = 0; i < N; i++) begin : g_part
      logic [RW-1:0] rd_q;
      logic [WW-1:0] wr_q;
      always_ff @(posedge clk) begin
         if (rst)               rd_q <= '0;
         else if (src_load[i])  rd_q <= RW'(BEATS);
         else if (rd_q != '0)   rd_q <= rd_q - 1'b1;
      end
      always_ff @(posedge clk) begin
         if (rst)               wr_q <= '0;
         else if (dst_load[i])  wr_q <= WW'(BEATS) + WW'(hops);
         else if (wr_q != '0)   wr_q <= wr_q - 1'b1;
      end
      assign src_free[i] = (rd_q == '0);
      assign dst_free[i] = (wr_q == '0);
      assign src_beat[i] = (rd_q != '0);
      assign dst_beat[i] = (wr_q != '0) && (wr_q <= WW'(BEATS));

      p_rd_start_r8: assert property (@(posedge clk) disable iff (rst)
         $rose(src_beat[i]) |-> $past(src_load[i]));
   end

   p_rd_port_r8: assert property (@(posedge clk) disable iff (rst)
      (src_load & ~src_free) == '0);
   p_wr_port_r9: assert property (@(posedge clk) disable iff (rst)
      (dst_load & ~dst_free) == '0);
endmodule

// File: rtl/ring_arbiter.sv
module ring_arbiter
   import ring_pkg::*;
#(
   parameter int N_NODES    = 12,
   parameter int MAX_HOPS   = 6,
   parameter int BEATS      = 8,
   parameter int CH_PER_DIR = 2,
   parameter int START_GAP  = 3
)(
   input  logic                                  clk,
   input  logic                                  rst,
   input  logic [N_NODES-1:0]                    req_valid,
   input  logic [N_NODES*$clog2(N_NODES)-1:0]    req_dst,
   output logic [N_NODES-1:0]                    gnt,
   output logic [N_NODES-1:0]                    err,
   output logic [$clog2(2*CH_PER_DIR)-1:0]       gnt_chan,
   output logic                                  gnt_cw,
   output logic [$clog2(MAX_HOPS+1)-1:0]         gnt_hops,
   output logic [N_NODES-1:0]                    src_beat,
   output logic [N_NODES-1:0]                    dst_beat
);
   localparam int IW  = $clog2(N_NODES);
   localparam int NCH = 2 * CH_PER_DIR;
   localparam int CHW = $clog2(NCH);
   localparam int HW  = $clog2(MAX_HOPS + 1);

   if (N_NODES < 3) begin : g_bad_nodes
      $error("ring needs at least three participants");
   end
   if (2 * MAX_HOPS < N_NODES || MAX_HOPS >= N_NODES) begin : g_bad_hops
      $error("hop cap must reach half the ring and stay below its length");
   end
   if (CH_PER_DIR < 1 || START_GAP < 1 || BEATS < 1) begin : g_bad_cfg
      $error("channel count, start spacing and burst length must be positive");
   end

   logic [IW-1:0]      dst_i  [N_NODES];
   logic [N_NODES-1:0] bad, rcw;
   logic [HW-1:0]      hop_i  [N_NODES];
   logic [N_NODES-1:0] path_i [N_NODES];

   for (genvar i = 0; i < N_NODES; i++) begin : g_node
      assign dst_i[i] = req_dst[i*IW +: IW];
      ring_route #(.N(N_NODES), .MAXH(MAX_HOPS), .SRC(i)) u_route (
         .dst(dst_i[i]), .bad(bad[i]), .cw(rcw[i]),
         .hops(hop_i[i]), .path(path_i[i]));
   end

   logic [N_NODES-1:0] seg_busy [NCH];
   logic [NCH-1:0]     start_ok, ch_load;
   logic [N_NODES-1:0] win_path;
   logic [IW-1:0]      win;
   logic               win_v;
   logic [IW-1:0]      rr_q;

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      ring_chan #(.N(N_NODES), .BEATS(BEATS), .MAXH(MAX_HOPS), .GAP(START_GAP),
                  .IS_CW(c < CH_PER_DIR)) u_chan (
         .clk(clk), .rst(rst), .load(ch_load[c]), .path(win_path), .src(win),
         .seg_busy(seg_busy[c]), .start_ok(start_ok[c]));
   end

   logic [N_NODES-1:0] src_free, dst_free, dst_onehot;
   logic [NCH-1:0]     ok_ch [N_NODES];
   logic [N_NODES-1:0] elig;

   always_comb begin
      for (int i = 0; i < N_NODES; i++) begin
         logic dfree;
         dfree = 1'b0;
         for (int n = 0; n < N_NODES; n++)
            if (int'(dst_i[i]) == n) dfree = dst_free[n];
         for (int c = 0; c < NCH; c++)
            ok_ch[i][c] = start_ok[c] && ((seg_busy[c] & path_i[i]) == '0)
                          && (rcw[i] == (c < CH_PER_DIR));
         elig[i] = req_valid[i] && !bad[i] && src_free[i] && dfree
                   && (ok_ch[i] != '0);
         err[i]  = req_valid[i] && bad[i];
      end
   end

   // Round-robin winner, then lowest usable channel of its direction.
   always_comb begin
      win_v = 1'b0;
      win   = '0;
      for (int k = 0; k < N_NODES; k++) begin
         int idx;
         idx = ring_wrap(int'(rr_q) + k, N_NODES);
         if (!win_v && elig[idx]) begin
            win_v = 1'b1;
            win   = IW'(idx);
         end
      end
      gnt_chan = '0;
      for (int c = NCH - 1; c >= 0; c--)
         if (ok_ch[win][c]) gnt_chan = CHW'(c);
      if (!win_v) gnt_chan = '0;
      win_path   = win_v ? path_i[win] : '0;
      gnt_cw     = win_v && rcw[win];
      gnt_hops   = win_v ? hop_i[win] : '0;
      gnt        = '0;
      dst_onehot = '0;
      ch_load    = '0;
      if (win_v) begin
         gnt[win] = 1'b1;
         for (int n = 0; n < N_NODES; n++)
            if (int'(dst_i[win]) == n) dst_onehot[n] = 1'b1;
         ch_load[gnt_chan] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)        rr_q <= '0;
      else if (win_v) rr_q <= IW'(ring_wrap(int'(win) + 1, N_NODES));
   end

   ring_port #(.N(N_NODES), .BEATS(BEATS), .MAXH(MAX_HOPS)) u_port (
      .clk(clk), .rst(rst), .src_load(gnt), .dst_load(dst_onehot), .hops(gnt_hops),
      .src_free(src_free), .dst_free(dst_free),
      .src_beat(src_beat), .dst_beat(dst_beat));

   p_one_grant_r4: assert property (@(posedge clk) disable iff (rst)
      $onehot0(gnt));
   p_no_bad_grant_r3: assert property (@(posedge clk) disable iff (rst)
      (gnt & (err | bad)) == '0);
   p_hop_cap_r1: assert property (@(posedge clk) disable iff (rst)
      (gnt != '0) |-> (gnt_hops != '0 && int'(gnt_hops) <= MAX_HOPS));
   p_dir_chan_r2: assert property (@(posedge clk) disable iff (rst)
      (gnt != '0) |-> (gnt_cw == (int'(gnt_chan) < CH_PER_DIR)));
   p_req_held_r4: assert property (@(posedge clk) disable iff (rst)
      (gnt & ~req_valid) == '0);
endmodule

// File: tb/sim_ring_arbiter.sv
module sim_ring_arbiter;
   localparam int CLK_P = 10;
   localparam int N  = 12;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [N-1:0]  reqv = '0;
   logic [N*IW-1:0] reqd = '0;
   logic [N-1:0]  gnt, err, src_beat, dst_beat;
   logic [1:0]    gnt_chan;
   logic          gnt_cw;
   logic [2:0]    gnt_hops;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [N-1:0] prev_drop = '0;

   always #(CLK_P/2) clk = ~clk;

   ring_arbiter u0 (
      .clk(clk), .rst(rst), .req_valid(reqv), .req_dst(reqd),
      .gnt(gnt), .err(err), .gnt_chan(gnt_chan), .gnt_cw(gnt_cw),
      .gnt_hops(gnt_hops), .src_beat(src_beat), .dst_beat(dst_beat));

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      reqv = '0;
      prev_drop = '0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   // One cycle: drop served/refused requests, add new ones, sample.
   task automatic run_cycle(input int s1 = -1, input int d1 = 0,
                            input int s2 = -1, input int d2 = 0,
                            input int s3 = -1, input int d3 = 0);
      @(negedge clk);
      reqv = reqv & ~prev_drop;
      if (s1 >= 0) begin reqv[s1] = 1'b1; reqd[s1*IW +: IW] = IW'(d1); end
      if (s2 >= 0) begin reqv[s2] = 1'b1; reqd[s2*IW +: IW] = IW'(d2); end
      if (s3 >= 0) begin reqv[s3] = 1'b1; reqd[s3*IW +: IW] = IW'(d3); end
      #1;
      prev_drop = gnt | err;
   endtask

   task automatic expect_grant(input string tag, input int src, input int chan);
      chk(gnt == N'(1 << src), tag, int'(gnt), 1 << src);
      chk(int'(gnt_chan) == chan, tag, int'(gnt_chan), chan);
   endtask

   initial begin
      #(CLK_P * 150000);
      fails++;
      $display("FAIL R4 watchdog act=0 exp=1");
      report();
   end

   initial begin
      do_reset();
      // R10: idle state after reset.
      run_cycle();
      chk(src_beat == '0 && dst_beat == '0, "R10 beats idle", int'(src_beat | dst_beat), 0);
      chk(gnt == '0 && err == '0, "R10 no grant", int'(gnt | err), 0);

      // R3: destination beyond the ring.
      run_cycle(3, 15);
      chk(err == N'(1 << 3), "R3 range err", int'(err), 1 << 3);
      chk(gnt == '0, "R3 range no grant", int'(gnt), 0);
      run_cycle();

      // R1 R2 R3 R8 R9: every pair alone on an idle ring.
      for (int s = 0; s < N; s++) begin
         for (int d = 0; d < N; d++) begin
            int dc, h, ch;
            bit cw;
            dc = (d - s + N) % N;
            cw = (dc <= 6);
            h  = cw ? dc : N - dc;
            ch = cw ? 0 : 2;
            run_cycle(s, d);
            if (s == d) begin
               chk(err == N'(1 << s), "R3 self err", int'(err), 1 << s);
               chk(gnt == '0, "R3 self no grant", int'(gnt), 0);
               run_cycle();
            end else begin
               expect_grant("R2 idle grant", s, ch);
               chk(gnt_cw == cw, "R1 direction", int'(gnt_cw), int'(cw));
               chk(int'(gnt_hops) == h, "R1 hops", int'(gnt_hops), h);
               chk(err == '0, "R3 no err", int'(err), 0);
               for (int m = 1; m <= 15; m++) begin
                  logic [N-1:0] es, ed;
                  run_cycle();
                  es = (m <= 8) ? N'(1 << s) : '0;
                  ed = (m >= h + 1 && m <= h + 8) ? N'(1 << d) : '0;
                  chk(src_beat == es, "R8 src beat", int'(src_beat), int'(es));
                  chk(dst_beat == ed, "R9 dst beat", int'(dst_beat), int'(ed));
               end
            end
         end
      end

      // R6 R4 R5: three disjoint clockwise requests at once.
      do_reset();
      run_cycle(0, 1, 5, 6, 8, 9);
      expect_grant("R5 first from zero", 0, 0);
      run_cycle();
      expect_grant("R6 second channel", 5, 1);
      run_cycle();
      chk(gnt == '0, "R6 both spaced", int'(gnt), 0);
      run_cycle();
      expect_grant("R6 channel reuse shared", 8, 0);

      // R7: overlapping routes.
      do_reset();
      run_cycle(0, 4);
      expect_grant("R7 first route", 0, 0);
      run_cycle(1, 3);
      expect_grant("R7 overlap moves channel", 1, 1);
      for (int c = 2; c <= 9; c++) begin
         run_cycle((c == 2) ? 11 : -1, 2);
         chk(gnt == '0, "R7 blocked", int'(gnt), 0);
      end
      run_cycle();
      expect_grant("R7 released", 11, 0);

      // R8: busy sender.
      do_reset();
      run_cycle(0, 1);
      expect_grant("R8 first", 0, 0);
      for (int c = 1; c <= 8; c++) begin
         run_cycle((c == 1) ? 0 : -1, 11);
         chk(gnt == '0, "R8 sender busy", int'(gnt), 0);
      end
      run_cycle();
      expect_grant("R8 sender free", 0, 2);

      // R9: busy receiver.
      do_reset();
      run_cycle(2, 4);
      expect_grant("R9 first", 2, 0);
      for (int c = 1; c <= 10; c++) begin
         run_cycle((c == 1) ? 6 : -1, 4);
         chk(gnt == '0, "R9 receiver busy", int'(gnt), 0);
      end
      run_cycle();
      expect_grant("R9 receiver free", 6, 2);

      // R5: pointer moves past the last winner.
      do_reset();
      run_cycle(5, 6);
      expect_grant("R5 lone", 5, 0);
      run_cycle(2, 3, 7, 8);
      expect_grant("R5 after last winner", 7, 1);
      run_cycle();
      chk(gnt == '0, "R6 spacing wait", int'(gnt), 0);
      run_cycle();
      expect_grant("R5 wrapped turn", 2, 0);

      report();
   end
endmodule